// File: doc/BRIEF.md
# Miss Hold Buffer

A non-blocking cache bank uses this block to park requests that missed, so the pipeline can keep running. A late pipeline stage writes a missed request into a free slot. The slot holds the line address, word select, write word, thread index, tag, read/write flag, byte enables, a snoop flag and a snoop-invalidate flag. A slot can start out waiting or start out ready. When a line fill is accepted, every waiting slot for that line becomes ready. Ready slots are offered back to the bank input for replay, oldest first.

An offered slot is marked issued by the schedule strobe, but it stays allocated. The bank carries the slot index down its pipeline. If the replay completes, the bank frees the slot with the retire strobe. If the replay misses again, the bank pushes it back with the replay flag, and it returns to the same slot.

The block also has a combinational hazard output. It reports whether any held slot targets the line currently at the bank input. The bank uses it to force a miss, so that requests to one line commit in order.

Top module: `miss_hold_buf`

## Requirements
- R1: Reset clears every slot and the allocation pointer to slot 0. After reset, `full`, `rp_valid` and `hazard` are all 0.
- R2: A new enqueue stores all nine payload fields. When the slot is offered, `rp_line`, `rp_wsel`, `rp_word`, `rp_tid`, `rp_tag`, `rp_rw`, `rp_ben`, `rp_snp` and `rp_snp_inv` show those stored values.
- R3: A new entry is ready if `enq_ready_now` is 1 when it is enqueued. It is then offered from the next cycle on. An entry enqueued with `enq_ready_now` at 0 is not offered until a matching fill arrives.
- R4: A fill strobe marks every held slot with an equal line address as ready, from the next cycle on. A new enqueue for the fill's line in the same cycle is also stored as ready.
- R5: `hazard` is 1 in the same cycle, with no register, whenever any held slot's line equals `probe_line`. This includes issued slots.
- R6: The offered slot is the first slot that is ready and not issued, scanning circularly from the allocation pointer. That order is allocation order, so the oldest slot wins. `rp_slot` gives its index. While `rp_valid` is 1, `sched` marks the slot issued, and it is not offered again.
- R7: An issued slot stays allocated. It keeps contributing to `hazard` and `full` until `retire_valid` names it. From the next cycle on, the slot is free.
- R8: A replay enqueue (`enq_replay`=1) returns slot `enq_slot` to waiting. The slot becomes ready if `enq_ready_now` is 1 or a same-line fill arrives in that cycle. The enqueue keeps the stored payload, ignores the payload inputs and does not move the allocation pointer.
- R9: New entries take slots in circular order at the allocation pointer. `full` is 1 while the slot at the pointer is still held, which is always the case when every slot is held. A new enqueue while `full` is 1 is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | Enqueue strobe |
| enq_replay | input | 1 | 1: re-miss of an issued slot; 0: new entry |
| enq_slot | input | IDX_W | Slot index for a replay enqueue |
| enq_ready_now | input | 1 | Store the entry as ready |
| enq_line | input | LINE_W | Line address |
| enq_wsel | input | WSEL_W | Word select |
| enq_word | input | WORD_W | Write word |
| enq_tid | input | TID_W | Thread index |
| enq_tag | input | TAG_W | Request tag |
| enq_rw | input | 1 | Write flag |
| enq_ben | input | BEN_W | Byte enables |
| enq_snp | input | 1 | Snoop flag |
| enq_snp_inv | input | 1 | Snoop-invalidate flag |
| full | output | 1 | Slot at the allocation pointer is held |
| fill_valid | input | 1 | Fill accepted this cycle |
| fill_line | input | LINE_W | Line address of the fill |
| probe_line | input | LINE_W | Line at the bank input |
| hazard | output | 1 | A held slot matches `probe_line` |
| sched | input | 1 | Take the offered slot for replay |
| rp_valid | output | 1 | A slot is offered |
| rp_slot | output | IDX_W | Index of the offered slot |
| rp_line | output | LINE_W | Offered line address |
| rp_wsel | output | WSEL_W | Offered word select |
| rp_word | output | WORD_W | Offered write word |
| rp_tid | output | TID_W | Offered thread index |
| rp_tag | output | TAG_W | Offered tag |
| rp_rw | output | 1 | Offered write flag |
| rp_ben | output | BEN_W | Offered byte enables |
| rp_snp | output | 1 | Offered snoop flag |
| rp_snp_inv | output | 1 | Offered snoop-invalidate flag |
| retire_valid | input | 1 | Replay of `retire_slot` completed |
| retire_slot | input | IDX_W | Slot to free |

## Verification
`hazard` follows `probe_line` within the same cycle. `rp_*` and `full` depend only on registered state, so each enqueue, fill, schedule or retire shows up exactly one clock edge after the cycle in which it was applied. The bench changes inputs just after the falling edge and samples the outputs 1 ns later, before the next rising edge. At that point the outputs reflect the state left by the previous steps and the probe of the current step. Each expected value in the vector table is therefore the effect of the steps before it.

// File: rtl/mhb_pkg.sv
package mhb_pkg;
    parameter int LINE_W = 8;
    parameter int WSEL_W = 2;
    parameter int WORD_W = 16;
    parameter int TID_W  = 2;
    parameter int TAG_W  = 4;
    parameter int BEN_W  = 2;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [WSEL_W-1:0] wsel;
        logic [WORD_W-1:0] word;
        logic [TID_W-1:0]  tid;
        logic [TAG_W-1:0]  tag;
        logic              rw;
        logic [BEN_W-1:0]  ben;
        logic              snp;
        logic              snp_inv;
    } mhb_payload_t;
endpackage

// File: rtl/mhb_line_match.sv
module mhb_line_match #(
    parameter int DEPTH = 4,
    parameter int LW    = 8
) (
    input  logic [DEPTH-1:0]         live,
    input  logic [DEPTH-1:0][LW-1:0] lines,
    input  logic [LW-1:0]            key,
    output logic [DEPTH-1:0]         hit
);
    for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
        assign hit[k] = live[k] && (lines[k] == key);
    end
endmodule

// File: rtl/mhb_age_pick.sv
module mhb_age_pick #(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] req,
    input  logic [IDX_W-1:0] base,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] b, input int k);
        int s;
        s = int'(b) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return IDX_W'(s);
    endfunction

    // first requesting slot at or after base, circularly
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (!found && req[wrap_add(base, k)]) begin
                found = 1'b1;
                idx   = wrap_add(base, k);
            end
        end
    end
endmodule

// File: rtl/miss_hold_buf.sv
module miss_hold_buf
    import mhb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic              enq_replay,
    input  logic [IDX_W-1:0]  enq_slot,
    input  logic              enq_ready_now,
    input  logic [LINE_W-1:0] enq_line,
    input  logic [WSEL_W-1:0] enq_wsel,
    input  logic [WORD_W-1:0] enq_word,
    input  logic [TID_W-1:0]  enq_tid,
    input  logic [TAG_W-1:0]  enq_tag,
    input  logic              enq_rw,
    input  logic [BEN_W-1:0]  enq_ben,
    input  logic              enq_snp,
    input  logic              enq_snp_inv,
    output logic              full,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [LINE_W-1:0] probe_line,
    output logic              hazard,
    input  logic              sched,
    output logic              rp_valid,
    output logic [IDX_W-1:0]  rp_slot,
    output logic [LINE_W-1:0] rp_line,
    output logic [WSEL_W-1:0] rp_wsel,
    output logic [WORD_W-1:0] rp_word,
    output logic [TID_W-1:0]  rp_tid,
    output logic [TAG_W-1:0]  rp_tag,
    output logic              rp_rw,
    output logic [BEN_W-1:0]  rp_ben,
    output logic              rp_snp,
    output logic              rp_snp_inv,
    input  logic              retire_valid,
    input  logic [IDX_W-1:0]  retire_slot
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0]               valid;
        logic [DEPTH-1:0]               ready;
        logic [DEPTH-1:0]               issued;
        logic [IDX_W-1:0]               tail;
        mhb_payload_t [DEPTH-1:0]       pay;
    } mhb_state_t;

    mhb_state_t st_d, st_q;

    logic [DEPTH-1:0][LINE_W-1:0] line_vec;
    logic [DEPTH-1:0]             fill_hit;
    logic [DEPTH-1:0]             probe_hit;
    logic [DEPTH-1:0]             offer_req;
    logic                         pick_found;
    logic [IDX_W-1:0]             pick_idx;
    mhb_payload_t                 new_pay;
    mhb_payload_t                 rp_pay;

    for (genvar k = 0; k < DEPTH; k++) begin : g_lines
        assign line_vec[k] = st_q.pay[k].line;
    end

    mhb_line_match #(.DEPTH(DEPTH), .LW(LINE_W)) u_fill_match (
        .live  (st_q.valid & {DEPTH{fill_valid}}),
        .lines (line_vec),
        .key   (fill_line),
        .hit   (fill_hit)
    );

    mhb_line_match #(.DEPTH(DEPTH), .LW(LINE_W)) u_probe_match (
        .live  (st_q.valid),
        .lines (line_vec),
        .key   (probe_line),
        .hit   (probe_hit)
    );

    assign offer_req = st_q.valid & st_q.ready & ~st_q.issued;

    mhb_age_pick #(.DEPTH(DEPTH)) u_pick (
        .req   (offer_req),
        .base  (st_q.tail),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        new_pay         = '0;
        new_pay.line    = enq_line;
        new_pay.wsel    = enq_wsel;
        new_pay.word    = enq_word;
        new_pay.tid     = enq_tid;
        new_pay.tag     = enq_tag;
        new_pay.rw      = enq_rw;
        new_pay.ben     = enq_ben;
        new_pay.snp     = enq_snp;
        new_pay.snp_inv = enq_snp_inv;
    end

    // next-state computation
    always_comb begin
        st_d = st_q;
        for (int k = 0; k < DEPTH; k++) begin
            if (fill_hit[k]) st_d.ready[k] = 1'b1;
        end
        if (sched && pick_found) st_d.issued[pick_idx] = 1'b1;
        if (retire_valid) begin
            st_d.valid[retire_slot]  = 1'b0;
            st_d.ready[retire_slot]  = 1'b0;
            st_d.issued[retire_slot] = 1'b0;
        end
        if (enq_valid) begin
            if (enq_replay) begin
                st_d.issued[enq_slot] = 1'b0;
                st_d.ready[enq_slot]  = enq_ready_now ||
                    (fill_valid && (fill_line == st_q.pay[enq_slot].line));
            end else begin
                st_d.valid[st_q.tail]  = 1'b1;
                st_d.issued[st_q.tail] = 1'b0;
                st_d.ready[st_q.tail]  = enq_ready_now ||
                    (fill_valid && (fill_line == enq_line));
                st_d.pay[st_q.tail]    = new_pay;
                st_d.tail = (st_q.tail == LAST) ? '0 : st_q.tail + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full       = st_q.valid[st_q.tail];
    assign hazard     = |probe_hit;
    assign rp_valid   = pick_found;
    assign rp_slot    = pick_idx;
    assign rp_pay     = st_q.pay[pick_idx];
    assign rp_line    = rp_pay.line;
    assign rp_wsel    = rp_pay.wsel;
    assign rp_word    = rp_pay.word;
    assign rp_tid     = rp_pay.tid;
    assign rp_tag     = rp_pay.tag;
    assign rp_rw      = rp_pay.rw;
    assign rp_ben     = rp_pay.ben;
    assign rp_snp     = rp_pay.snp;
    assign rp_snp_inv = rp_pay.snp_inv;

    // R9: the caller must stall before the allocation slot is taken
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !enq_replay) |-> !full);

    // R8: a replay returns to a slot that is held and issued
    p_replay_slot_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_replay) |-> (st_q.valid[enq_slot] && st_q.issued[enq_slot]));

    // R6: a scheduled slot is not offered again in the next cycle
    p_no_reoffer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sched && rp_valid && !(enq_valid && enq_replay && enq_slot == rp_slot))
        |=> !(rp_valid && rp_slot == $past(rp_slot)));

    // R7: a retired slot is free afterwards
    p_retire_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |=> !st_q.valid[$past(retire_slot)]);

    for (genvar k = 0; k < DEPTH; k++) begin : g_fill_chk
        // R4: a fill makes every matching held slot ready
        p_fill_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_valid && st_q.valid[k] && st_q.pay[k].line == fill_line
             && !(retire_valid && retire_slot == IDX_W'(k))
             && !(enq_valid && enq_replay && enq_slot == IDX_W'(k)))
            |=> st_q.ready[k]);
    end
endmodule

// File: tb/miss_hold_buf_tb_top.sv
`timescale 1ns/1ps
module miss_hold_buf_tb_top;
    logic clk = 1'b0;
    logic rst_n;
    always #2.5 clk = ~clk;

    logic       enq_valid, enq_replay, enq_ready_now;
    logic [1:0] enq_slot;
    logic [7:0] enq_line;
    logic [1:0] enq_wsel;
    logic [15:0] enq_word;
    logic [1:0] enq_tid;
    logic [3:0] enq_tag;
    logic       enq_rw, enq_snp, enq_snp_inv;
    logic [1:0] enq_ben;
    logic       full, fill_valid, hazard, sched, rp_valid, retire_valid;
    logic [7:0] fill_line, probe_line, rp_line;
    logic [1:0] rp_slot, rp_wsel, rp_tid, rp_ben, retire_slot;
    logic [15:0] rp_word;
    logic [3:0] rp_tag;
    logic       rp_rw, rp_snp, rp_snp_inv;

    miss_hold_buf dut_i (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_replay(enq_replay), .enq_slot(enq_slot),
        .enq_ready_now(enq_ready_now), .enq_line(enq_line), .enq_wsel(enq_wsel),
        .enq_word(enq_word), .enq_tid(enq_tid), .enq_tag(enq_tag), .enq_rw(enq_rw),
        .enq_ben(enq_ben), .enq_snp(enq_snp), .enq_snp_inv(enq_snp_inv),
        .full(full), .fill_valid(fill_valid), .fill_line(fill_line),
        .probe_line(probe_line), .hazard(hazard), .sched(sched),
        .rp_valid(rp_valid), .rp_slot(rp_slot), .rp_line(rp_line), .rp_wsel(rp_wsel),
        .rp_word(rp_word), .rp_tid(rp_tid), .rp_tag(rp_tag), .rp_rw(rp_rw),
        .rp_ben(rp_ben), .rp_snp(rp_snp), .rp_snp_inv(rp_snp_inv),
        .retire_valid(retire_valid), .retire_slot(retire_slot)
    );

    typedef struct packed {
        logic       enq, rp;
        logic [1:0] slot;
        logic       rdy;
        logic [7:0] line;
        logic       fv;
        logic [7:0] fline;
        logic [7:0] probe;
        logic       sch, rv;
        logic [1:0] rslot;
        logic       xf, xh, xv;
        logic [1:0] xs;
        logic [7:0] xl;
    } vec_t;

    localparam int NV = 19;
    // enq rp slot rdy line | fv fline | probe | sch rv rslot | full haz rpv slot line
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,2'd0,1'b0,8'h00, 1'b0,8'h00, 8'h10, 1'b0,1'b0,2'd0, 1'b0,1'b0,1'b0,2'd0,8'h00},
        '{1'b1,1'b0,2'd0,1'b0,8'h10, 1'b0,8'h00, 8'h10, 1'b0,1'b0,2'd0, 1'b0,1'b0,1'b0,2'd0,8'h00},
        '{1'b1,1'b0,2'd0,1'b1,8'h20, 1'b0,8'h00, 8'h10, 1'b0,1'b0,2'd0, 1'b0,1'b1,1'b0,2'd0,8'h00},
        '{1'b0,1'b0,2'd0,1'b0,8'h00, 1'b0,8'h00, 8'h30, 1'b0,1'b0,2'd0, 1'b0,1'b0,1'b1,2'd1,8'h20},
        '{1'b1,1'b0,2'd0,1'b0,8'h10, 1'b1,8'h10, 8'h20, 1'b0,1'b0,2'd0, 1'b0,1'b1,1'b1,2'd1,8'h20},
        '{1'b0,1'b0,2'd0,1'b0,8'h00, 1'b0,8'h00, 8'h55, 1'b1,1'b0,2'd0, 1'b0,1'b0,1'b1,2'd0,8'h10},
        '{1'b0,1'b0,2'd0,1'b0,8'h00, 1'b0,8'h00, 8'h00, 1'b1,1'b0,2'd0, 1'b0,1'b0,1'b1,2'd1,8'h20},
        '{1'b1,1'b0,2'd0,1'b0,8'h40, 1'b0,8'h00, 8'h00, 1'b1,1'b0,2'd0, 1'b0,1'b0,1'b1,2'd2,8'h10},
        '{1'b0,1'b0,2'd0,1'b0,8'h00, 1'b0,8'h00, 8'h40, 1'b0,1'b0,2'd0, 1'b1,1'b1,1'b0,2'd0,8'h00},
        '{1'b0,1'b0,2'd0,1'b0,8'h00, 1'b0,8'h00, 8'h00, 1'b0,1'b1,2'd1, 1'b1,1'b0,1'b0,2'd0,8'h00},
        '{1'b1,1'b1,2'd0,1'b0,8'h10, 1'b0,8'h00, 8'h20, 1'b0,1'b0,2'd0, 1'b1,1'b0,1'b0,2'd0,8'h00},
        '{1'b0,1'b0,2'd0,1'b0,8'h00, 1'b1,8'h10, 8'h10, 1'b0,1'b0,2'd0, 1'b1,1'b1,1'b0,2'd0,8'h00},
        '{1'b0,1'b0,2'd0,1'b0,8'h00, 1'b0,8'h00, 8'h00, 1'b0,1'b1,2'd2, 1'b1,1'b0,1'b1,2'd0,8'h10},
        '{1'b0,1'b0,2'd0,1'b0,8'h00, 1'b0,8'h00, 8'h00, 1'b1,1'b0,2'd0, 1'b1,1'b0,1'b1,2'd0,8'h10},
        '{1'b0,1'b0,2'd0,1'b0,8'h00, 1'b0,8'h00, 8'h10, 1'b0,1'b1,2'd0, 1'b1,1'b1,1'b0,2'd0,8'h00},
        '{1'b1,1'b0,2'd0,1'b1,8'h50, 1'b0,8'h00, 8'h10, 1'b0,1'b0,2'd0, 1'b0,1'b0,1'b0,2'd0,8'h00},
        '{1'b0,1'b0,2'd0,1'b0,8'h00, 1'b1,8'h40, 8'h50, 1'b0,1'b0,2'd0, 1'b0,1'b1,1'b1,2'd0,8'h50},
        '{1'b0,1'b0,2'd0,1'b0,8'h00, 1'b0,8'h00, 8'h40, 1'b1,1'b0,2'd0, 1'b0,1'b1,1'b1,2'd3,8'h40},
        '{1'b0,1'b0,2'd0,1'b0,8'h00, 1'b0,8'h00, 8'h00, 1'b0,1'b0,2'd0, 1'b0,1'b0,1'b1,2'd0,8'h50}
    };

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic idle();
        enq_valid = 1'b0; enq_replay = 1'b0; enq_slot = '0; enq_ready_now = 1'b0;
        enq_line = '0; enq_wsel = '0; enq_word = '0; enq_tid = '0; enq_tag = '0;
        enq_rw = 1'b0; enq_ben = '0; enq_snp = 1'b0; enq_snp_inv = 1'b0;
        fill_valid = 1'b0; fill_line = '0; probe_line = '0;
        sched = 1'b0; retire_valid = 1'b0; retire_slot = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic enq_new(input logic [7:0] line, input logic rdy);
        enq_valid = 1'b1; enq_replay = 1'b0; enq_line = line; enq_ready_now = rdy;
    endtask

    initial begin
        rst_n = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // table walk: R3 R4 R5 R6 R7 R8 R9 ordering and hazard behaviour
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle();
            enq_valid = VEC[i].enq; enq_replay = VEC[i].rp; enq_slot = VEC[i].slot;
            enq_ready_now = VEC[i].rdy; enq_line = VEC[i].line;
            fill_valid = VEC[i].fv; fill_line = VEC[i].fline; probe_line = VEC[i].probe;
            sched = VEC[i].sch; retire_valid = VEC[i].rv; retire_slot = VEC[i].rslot;
            #1;
            chk("R9", $sformatf("v%0d full", i), 32'(full), 32'(VEC[i].xf));
            chk("R5", $sformatf("v%0d hazard", i), 32'(hazard), 32'(VEC[i].xh));
            chk("R6", $sformatf("v%0d rp_valid", i), 32'(rp_valid), 32'(VEC[i].xv));
            if (VEC[i].xv) begin
                chk("R6", $sformatf("v%0d rp_slot", i), 32'(rp_slot), 32'(VEC[i].xs));
                chk("R4", $sformatf("v%0d rp_line", i), 32'(rp_line), 32'(VEC[i].xl));
            end
        end

        // R1: reset clears a populated buffer
        @(negedge clk);
        rst_n = 1'b0;
        idle();
        probe_line = 8'h50;
        #1;
        chk("R1", "full", 32'(full), 32'd0);
        chk("R1", "rp_valid", 32'(rp_valid), 32'd0);
        chk("R1", "hazard", 32'(hazard), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3: payload of a ready-at-insert entry
        @(negedge clk);
        idle();
        enq_new(8'hA5, 1'b1);
        enq_wsel = 2'd3; enq_word = 16'hBEEF; enq_tid = 2'd2; enq_tag = 4'h9;
        enq_rw = 1'b1; enq_ben = 2'b10; enq_snp = 1'b1; enq_snp_inv = 1'b1;
        #1;
        chk("R3", "rp_valid before insert", 32'(rp_valid), 32'd0);
        @(negedge clk);
        idle();
        probe_line = 8'hA5;
        sched = 1'b1;
        #1;
        chk("R3", "rp_valid", 32'(rp_valid), 32'd1);
        chk("R2", "rp_slot", 32'(rp_slot), 32'd0);
        chk("R2", "rp_line", 32'(rp_line), 32'hA5);
        chk("R2", "rp_wsel", 32'(rp_wsel), 32'd3);
        chk("R2", "rp_word", 32'(rp_word), 32'hBEEF);
        chk("R2", "rp_tid", 32'(rp_tid), 32'd2);
        chk("R2", "rp_tag", 32'(rp_tag), 32'h9);
        chk("R2", "rp_rw", 32'(rp_rw), 32'd1);
        chk("R2", "rp_ben", 32'(rp_ben), 32'd2);
        chk("R2", "rp_snp", 32'(rp_snp), 32'd1);
        chk("R2", "rp_snp_inv", 32'(rp_snp_inv), 32'd1);
        chk("R5", "hazard on held line", 32'(hazard), 32'd1);

        // R8: replay keeps the payload and the slot
        @(negedge clk);
        idle();
        probe_line = 8'hA5;
        enq_valid = 1'b1; enq_replay = 1'b1; enq_slot = 2'd0; enq_ready_now = 1'b1;
        enq_line = 8'h33; enq_word = 16'h1234; enq_tag = 4'h1;
        #1;
        chk("R6", "issued slot not offered", 32'(rp_valid), 32'd0);
        chk("R7", "issued slot still hazards", 32'(hazard), 32'd1);
        @(negedge clk);
        idle();
        probe_line = 8'h33;
        sched = 1'b1;
        #1;
        chk("R8", "payload line not replaced", 32'(hazard), 32'd0);
        chk("R8", "rp_valid after replay", 32'(rp_valid), 32'd1);
        chk("R8", "rp_slot reused", 32'(rp_slot), 32'd0);
        chk("R8", "rp_line kept", 32'(rp_line), 32'hA5);
        chk("R8", "rp_word kept", 32'(rp_word), 32'hBEEF);
        @(negedge clk);
        idle();
        enq_new(8'h11, 1'b1);
        #1;
        chk("R6", "nothing offered", 32'(rp_valid), 32'd0);
        @(negedge clk);
        idle();
        #1;
        chk("R8", "new entry took slot 1", 32'(rp_slot), 32'd1);
        chk("R8", "new entry line", 32'(rp_line), 32'h11);

        // R9 R3 R4 R7: fill every slot, wake one, retire it out of order
        do_reset();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            idle();
            enq_new(8'h61 + 8'(k), 1'b0);
        end
        @(negedge clk);
        idle();
        #1;
        chk("R9", "three held not full", 32'(full), 32'd0);
        enq_new(8'h64, 1'b0);
        @(negedge clk);
        idle();
        fill_line = 8'h62; fill_valid = 1'b1;
        #1;
        chk("R9", "four held full", 32'(full), 32'd1);
        chk("R3", "waiting entries not offered", 32'(rp_valid), 32'd0);
        @(negedge clk);
        idle();
        sched = 1'b1;
        #1;
        chk("R4", "fill wakes entry", 32'(rp_valid), 32'd1);
        chk("R4", "woken slot", 32'(rp_slot), 32'd1);
        chk("R4", "woken line", 32'(rp_line), 32'h62);
        @(negedge clk);
        idle();
        retire_valid = 1'b1; retire_slot = 2'd1;
        @(negedge clk);
        idle();
        probe_line = 8'h62;
        #1;
        chk("R7", "retired line no hazard", 32'(hazard), 32'd0);
        chk("R9", "pointer slot still held", 32'(full), 32'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule